// File: doc/BRIEF.md
# USB Core Clock-Gating Power Controller

This block manages power for a full-speed dual-role USB core. Software configures it through a small register port that keeps working in every power state. One register powers the line transceiver and turns on the bus-voltage comparators for the host role and for the peripheral role. A second register stops the 48 MHz USB domain, gates the system-clock domain of the core and requests deep sleep. A third register holds the wakeup status.

Gating is modelled as clock-enable outputs, one for each domain. The data FIFO gets its own enable, which is high only in cycles where the core accesses the FIFO. While the transceiver is powered down, or its clock is stopped, the received line state is forced quiet.

When both domains are gated, a detector that needs no clock watches the raw bus lines. Any state other than the idle state counts as resume or remote-wakeup signalling. The detector latches the event, passes it through synchronizers into each domain, clears the gating and sleep bits, and raises a wakeup flag that software clears by writing a one.

Top module: `usb_pwr_gate_ctrl`

## Requirements
- R1: After reset, all three registers read zero. The transceiver and both sense enables are off, `usb_clk_en` and `sys_clk_en` are 1, and `deep_sleep_req` is 0.
- R2: Register 0 holds bit 0 = transceiver power, bit 1 = host-role sensing and bit 2 = peripheral-role sensing. Each bit reads back as written and drives its output pin.
- R3: `rx_dp`/`rx_dm` follow `line_dp`/`line_dm` only while the transceiver is powered and register 1 bit 0 (stop-PHY-clock) is clear. Otherwise both are 0.
- R4: Setting register 1 bit 0 drops `usb_clk_en` within SYNC_STAGES+1 USB clocks. Clearing the bit restores it within the same bound.
- R5: Register 1 bit 1 (gate-system-clock) drives `sys_clk_en` low from the cycle after the write. Register writes and reads keep working while the bit is set.
- R6: `fifo_clk_en` is high in exactly the cycles where `fifo_access` is high and the system domain is not gated.
- R7: Register 1 bit 2 (deep sleep) is accepted only if bit 0 was already set before the write, bit 0 stays set in the same write, and `bus_suspended` is 1. Otherwise the written 1 is ignored. `deep_sleep_req` mirrors the bit.
- R8: Wakeup arms while bits 0 and 1 of register 1 are both set and the transceiver is powered. If the line then leaves the idle state (dp=1, dm=0), bits 0 to 2 of register 1 are cleared within SYNC_STAGES+2 system clocks, register 2 bit 0 is set, and `usb_clk_en` and `sys_clk_en` return to 1.
- R9: Register 2 bit 0 is cleared only by writing 1 to it. Writing 0 leaves it set.
- R10: With either gating bit clear, a non-idle line state changes no register and raises no wakeup flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock, register port domain |
| clk_usb | input | 1 | 48 MHz USB domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 config, 1 gating, 2 status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| bus_suspended | input | 1 | Bus is in the suspended state |
| line_dp | input | 1 | Raw D+ line state |
| line_dm | input | 1 | Raw D- line state |
| fifo_access | input | 1 | Core accesses the data FIFO this cycle |
| phy_pwr_on | output | 1 | Transceiver power enable |
| sense_host_en | output | 1 | Host-role bus-voltage comparator enable |
| sense_dev_en | output | 1 | Peripheral-role bus-voltage comparator enable |
| rx_dp | output | 1 | Received D+ seen by the core |
| rx_dm | output | 1 | Received D- seen by the core |
| usb_clk_en | output | 1 | Clock enable for the USB domain |
| sys_clk_en | output | 1 | Clock enable for the core's system domain |
| fifo_clk_en | output | 1 | Clock enable for the data FIFO |
| deep_sleep_req | output | 1 | Deep-sleep request to the power manager |

## Verification
If a gating bit is lost or stuck, it shows on the clock-enable pins. For the system domain this happens in the cycle after the write. For the USB domain it takes a few USB clocks, through the synchronizer. A sleep bit taken in the wrong order shows on `deep_sleep_req` and in the register 1 read on the next cycle. A broken wake path leaves the gating bits set and the status flag clear. The bench reads register 1 and register 2 a few cycles after the line leaves idle, so such a fault shows well within the synchronizer latency plus two cycles.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;

   localparam int unsigned REG_CFG  = 0;
   localparam int unsigned REG_GATE = 1;
   localparam int unsigned REG_STAT = 2;

   typedef struct packed {
      logic sense_dev;
      logic sense_host;
      logic pwr_on;
   } cfg_t;

   typedef struct packed {
      logic sleep;
      logic gate_sys;
      logic stop_phy;
   } gate_t;

   localparam logic [1:0] LINE_IDLE = 2'b10;

endpackage

// File: rtl/usb_pwr_sync.sv
module usb_pwr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("usb_pwr_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
   import usb_pwr_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              bus_suspended,
   input  logic              wake_pulse,
   output cfg_t              cfg,
   output gate_t             gate,
   output logic              wake_flag
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(REG_CFG);
   localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(REG_GATE);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

   logic wr_cfg, wr_gate, wr_stat;
   logic sleep_ok;
   logic unused_hi;

   assign wr_cfg   = wr && (addr == A_CFG);
   assign wr_gate  = wr && (addr == A_GATE);
   assign wr_stat  = wr && (addr == A_STAT);
   assign sleep_ok = wdata[2] && wdata[0] && gate.stop_phy && bus_suspended;
   assign unused_hi = ^wdata[DATA_W-1:3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_cfg) begin
         cfg.pwr_on     <= wdata[0];
         cfg.sense_host <= wdata[1];
         cfg.sense_dev  <= wdata[2];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate      <= '0;
         wake_flag <= 1'b0;
      end else if (wake_pulse) begin
         gate      <= '0;
         wake_flag <= 1'b1;
      end else begin
         if (wr_gate) begin
            gate.stop_phy <= wdata[0];
            gate.gate_sys <= wdata[1];
            gate.sleep    <= sleep_ok;
         end
         if (wr_stat && wdata[0]) wake_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_CFG)       rdata[2:0] = cfg;
      else if (addr == A_GATE) rdata[2:0] = gate;
      else if (addr == A_STAT) rdata[0]   = wake_flag;
   end

   a_r7_sleep_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
      gate.sleep |-> gate.stop_phy);
   a_r7_sleep_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate.sleep) |-> $past(gate.stop_phy) && $past(bus_suspended));
   a_r8_wake_clears_gating: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> (gate == '0));
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !(wr_stat && wdata[0])) |=> wake_flag);
endmodule

// File: rtl/usb_pwr_wake.sv
module usb_pwr_wake #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic armed,
   input  logic line_active,
   output logic wake_sys_lvl,
   output logic wake_pulse
);
   logic wake_set;
   logic latch_q;
   logic lvl_d;

   assign wake_set = armed && line_active;

   always_ff @(posedge clk_sys or negedge rst_n or posedge wake_set) begin
      if (!rst_n)            latch_q <= 1'b0;
      else if (wake_set)     latch_q <= 1'b1;
      else if (wake_sys_lvl) latch_q <= 1'b0;
   end

   usb_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync_sys (
      .clk(clk_sys), .rst_n(rst_n), .d(latch_q), .q(wake_sys_lvl));

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= wake_sys_lvl;
   end

   assign wake_pulse = wake_sys_lvl && !lvl_d;

   a_r8_single_pulse: assert property (@(posedge clk_sys) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
endmodule

// File: rtl/usb_pwr_usb_dom.sv
module usb_pwr_usb_dom #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_usb,
   input  logic rst_n,
   input  logic stop_req,
   input  logic wake_lvl,
   output logic usb_clk_en
);
   logic stop_s, wake_s;

   usb_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
      .clk(clk_usb), .rst_n(rst_n), .d(stop_req), .q(stop_s));
   usb_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync_wake (
      .clk(clk_usb), .rst_n(rst_n), .d(wake_lvl), .q(wake_s));

   always_ff @(posedge clk_usb or negedge rst_n) begin
      if (!rst_n) usb_clk_en <= 1'b1;
      else        usb_clk_en <= !stop_s || wake_s;
   end
endmodule

// File: rtl/usb_pwr_gate_ctrl.sv
module usb_pwr_gate_ctrl
   import usb_pwr_pkg::*;
#(
   parameter int unsigned ADDR_W         = 4,
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          WAKE_NEEDS_PWR = 1'b1
) (
   input  logic              clk_sys,
   input  logic              clk_usb,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_suspended,
   input  logic              line_dp,
   input  logic              line_dm,
   input  logic              fifo_access,
   output logic              phy_pwr_on,
   output logic              sense_host_en,
   output logic              sense_dev_en,
   output logic              rx_dp,
   output logic              rx_dm,
   output logic              usb_clk_en,
   output logic              sys_clk_en,
   output logic              fifo_clk_en,
   output logic              deep_sleep_req
);
   cfg_t  cfg;
   gate_t gate;
   logic  wake_flag, wake_pulse, wake_lvl;
   logic  armed, line_active, rx_open;

   generate
      if (DATA_W < 3) begin : g_bad_data
         $error("usb_pwr_gate_ctrl needs DATA_W of at least 3");
      end
      if ((1 << ADDR_W) <= REG_STAT) begin : g_bad_addr
         $error("usb_pwr_gate_ctrl needs room for three registers");
      end
      if (WAKE_NEEDS_PWR) begin : g_arm_pwr
         assign armed = gate.stop_phy && gate.gate_sys && cfg.pwr_on;
      end else begin : g_arm_any
         assign armed = gate.stop_phy && gate.gate_sys;
      end
   endgenerate

   usb_pwr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk_sys), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .bus_suspended(bus_suspended),
      .wake_pulse(wake_pulse), .cfg(cfg), .gate(gate), .wake_flag(wake_flag));

   assign line_active = ({line_dp, line_dm} != LINE_IDLE);

   usb_pwr_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk_sys(clk_sys), .rst_n(rst_n), .armed(armed),
      .line_active(line_active), .wake_sys_lvl(wake_lvl), .wake_pulse(wake_pulse));

   usb_pwr_usb_dom #(.SYNC_STAGES(SYNC_STAGES)) u_usb (
      .clk_usb(clk_usb), .rst_n(rst_n), .stop_req(gate.stop_phy),
      .wake_lvl(wake_lvl), .usb_clk_en(usb_clk_en));

   assign rx_open        = cfg.pwr_on && !gate.stop_phy;
   assign rx_dp          = rx_open && line_dp;
   assign rx_dm          = rx_open && line_dm;
   assign phy_pwr_on     = cfg.pwr_on;
   assign sense_host_en  = cfg.sense_host;
   assign sense_dev_en   = cfg.sense_dev;
   assign sys_clk_en     = !gate.gate_sys;
   assign fifo_clk_en    = fifo_access && sys_clk_en;
   assign deep_sleep_req = gate.sleep;

   a_r3_quiet_when_off: assert property (@(posedge clk_sys) disable iff (!rst_n)
      !phy_pwr_on |-> !rx_dp && !rx_dm);
   a_r6_fifo_on_access: assert property (@(posedge clk_sys) disable iff (!rst_n)
      fifo_clk_en |-> fifo_access && sys_clk_en);
   a_r10_flag_needs_arm: assert property (@(posedge clk_sys) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(wake_lvl));
endmodule

// File: tb/usb_pwr_gate_ctrl_bench.sv
module usb_pwr_gate_ctrl_bench;
   localparam int AW = 4;
   localparam int DW = 8;

   logic clk_sys = 1'b0, clk_usb = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic bus_suspended = 1'b0, line_dp = 1'b1, line_dm = 1'b0, fifo_access = 1'b0;
   logic phy_pwr_on, sense_host_en, sense_dev_en, rx_dp, rx_dm;
   logic usb_clk_en, sys_clk_en, fifo_clk_en, deep_sleep_req;

   int n_checks = 0;
   int n_fail   = 0;

   always #5  clk_sys = ~clk_sys;
   always #10 clk_usb = ~clk_usb;

   usb_pwr_gate_ctrl u_usb_pwr_gate_ctrl (
      .clk_sys(clk_sys), .clk_usb(clk_usb), .rst_n(rst_n), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .bus_suspended(bus_suspended), .line_dp(line_dp), .line_dm(line_dm),
      .fifo_access(fifo_access), .phy_pwr_on(phy_pwr_on),
      .sense_host_en(sense_host_en), .sense_dev_en(sense_dev_en),
      .rx_dp(rx_dp), .rx_dm(rx_dm), .usb_clk_en(usb_clk_en),
      .sys_clk_en(sys_clk_en), .fifo_clk_en(fifo_clk_en),
      .deep_sleep_req(deep_sleep_req));

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk_sys);
      reg_addr = AW'(a); reg_wdata = DW'(d); reg_wr = 1'b1;
      @(negedge clk_sys);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk_sys);
      reg_addr = AW'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic wait_sys(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_sys);
   endtask

   task automatic wait_usb(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_usb);
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 3; a++) begin
         rd(a, v); check("R1 reg readback", v, 0);
      end
      check("R1 usb_clk_en", int'(usb_clk_en), 1);
      check("R1 sys_clk_en", int'(sys_clk_en), 1);
      check("R1 deep_sleep_req", int'(deep_sleep_req), 0);
      check("R1 outputs off", int'({phy_pwr_on, sense_host_en, sense_dev_en}), 0);
   endtask

   task automatic t_cfg();
      int v;
      wr(0, 7); rd(0, v);
      check("R2 cfg readback all", v, 7);
      check("R2 cfg pins all", int'({phy_pwr_on, sense_host_en, sense_dev_en}), 7);
      wr(0, 2); rd(0, v);
      check("R2 cfg readback host", v, 2);
      check("R2 cfg pins host", int'({phy_pwr_on, sense_host_en, sense_dev_en}), 2);
   endtask

   task automatic t_line();
      wr(0, 1);
      line_dp = 1'b0; line_dm = 1'b1; #1;
      check("R3 rx follows K", int'({rx_dp, rx_dm}), 1);
      wr(1, 1); #1;
      check("R3 rx quiet when stopped", int'({rx_dp, rx_dm}), 0);
      wr(1, 0); wr(0, 0); #1;
      check("R3 rx quiet when off", int'({rx_dp, rx_dm}), 0);
      line_dp = 1'b1; line_dm = 1'b0;
   endtask

   task automatic t_stop_phy();
      wr(1, 1); wait_usb(4);
      check("R4 usb_clk_en gated", int'(usb_clk_en), 0);
      wr(1, 0); wait_usb(4);
      check("R4 usb_clk_en restored", int'(usb_clk_en), 1);
   endtask

   task automatic t_gate_sys();
      int v;
      fifo_access = 1'b1; #1;
      check("R6 fifo enable on access", int'(fifo_clk_en), 1);
      wr(1, 2);
      check("R5 sys_clk_en gated", int'(sys_clk_en), 0);
      check("R6 fifo off while gated", int'(fifo_clk_en), 0);
      wr(0, 4); rd(0, v);
      check("R5 write works while gated", v, 4);
      wr(1, 0);
      check("R5 sys_clk_en restored", int'(sys_clk_en), 1);
      fifo_access = 1'b0; #1;
      check("R6 fifo off without access", int'(fifo_clk_en), 0);
      wr(0, 0);
   endtask

   task automatic t_sleep();
      int v;
      bus_suspended = 1'b1;
      wr(1, 5); rd(1, v);
      check("R7 sleep with stop in same write ignored", v, 1);
      bus_suspended = 1'b0;
      wr(1, 5);
      check("R7 sleep without suspend ignored", int'(deep_sleep_req), 0);
      bus_suspended = 1'b1;
      wr(1, 5); rd(1, v);
      check("R7 sleep accepted readback", v, 5);
      check("R7 deep_sleep_req", int'(deep_sleep_req), 1);
      wr(1, 0);
      check("R7 sleep released", int'(deep_sleep_req), 0);
   endtask

   task automatic t_wake();
      int v;
      wr(0, 1); wr(1, 3); wr(1, 7);
      check("R8 armed and sleeping", int'({deep_sleep_req, sys_clk_en}), 2);
      line_dp = 1'b0; line_dm = 1'b1;
      wait_sys(6);
      rd(1, v); check("R8 gating cleared", v, 0);
      rd(2, v); check("R8 wake flag set", v, 1);
      check("R8 sys_clk_en back", int'(sys_clk_en), 1);
      wait_usb(6);
      check("R8 usb_clk_en back", int'(usb_clk_en), 1);
      line_dp = 1'b1; line_dm = 1'b0;
   endtask

   task automatic t_w1c();
      int v;
      wr(2, 0); rd(2, v);
      check("R9 write zero keeps flag", v, 1);
      wr(2, 1); rd(2, v);
      check("R9 write one clears flag", v, 0);
   endtask

   task automatic t_not_armed();
      int v;
      wr(1, 1);
      line_dp = 1'b0; line_dm = 1'b0;
      wait_sys(8);
      rd(1, v); check("R10 stop-only unchanged", v, 1);
      rd(2, v); check("R10 no flag stop-only", v, 0);
      wr(1, 2); wait_sys(8);
      rd(1, v); check("R10 gate-only unchanged", v, 2);
      rd(2, v); check("R10 no flag gate-only", v, 0);
      line_dp = 1'b1; line_dm = 1'b0;
      wr(1, 0); wr(0, 0);
   endtask

   initial begin
      #2000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait_sys(3);
      rst_n = 1'b1;
      wait_sys(2);
      t_reset();
      t_cfg();
      t_line();
      t_stop_phy();
      t_gate_sys();
      t_sleep();
      t_wake();
      t_w1c();
      t_not_armed();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule